// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block stands between the synchronised transmit data level and the control of the low-side bus driver. A low transmit level asks for a dominant bus and a high level leaves the bus recessive; an undriven input reads high. The guard stops a transmit input that is stuck low from holding the bus dominant for ever. It counts the low time in ticks of a shared timebase and, once that time reaches a limit, it forces the driver off and raises a status flag.

Re-enabling is deliberately strict. The driver comes back only after the transmit level has been high without a break for a set number of ticks. The same rule guards every entry into normal mode and the state after reset, so a transmit level that is already low at mode entry can never pull the bus low. Outside normal mode the driver is always off. Both durations are parameters counted in ticks.

Top module: `tdg_guard`

## Requirements
- R1: While the driver is enabled and normal mode is on, `drv_dom_o` is 1 when `txd_i` is 0 and 0 when `txd_i` is 1, without a clock delay.
- R2: While the driver is enabled, `txd_i` held at 0 for `TMO_TICKS` cycles with `tick_i` = 1 disables the driver at the edge of the last of those cycles. From then on `drv_dom_o` stays 0 even with `txd_i` still 0. Fewer such ticks change nothing.
- R3: A disabled driver is enabled again, in normal mode only, at the edge of the `REL_TICKS`-th cycle with `tick_i` = 1 in a row that sees `txd_i` = 1. Cycles with `tick_i` = 0 do not count.
- R4: Any cycle that samples `txd_i` = 0 restarts the release count from zero.
- R5: Any cycle that samples `txd_i` = 1 restarts the timeout count from zero.
- R6: With `norm_i` = 0, `drv_dom_o` is 0 and the driver is disabled at the next edge. After returning to normal mode the release rule of R3 must be met again, even if `txd_i` is 0 on entry.
- R7: While `rst_ni` = 0, and right after reset, the driver is disabled and `tmo_flag_o` is 0. Enabling then needs the release of R3.
- R8: `tmo_flag_o` becomes 1 at the edge where a timeout disables the driver. It stays 1, even through periods out of normal mode, until the edge where a release enables the driver again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Synchronised transmit level: 0 requests dominant |
| norm_i | input | 1 | 1 while the transceiver is in normal mode |
| tick_i | input | 1 | One-cycle timebase pulse that advances both timers |
| drv_dom_o | output | 1 | 1 commands the driver to pull the bus dominant |
| tmo_flag_o | output | 1 | 1 from a timeout until the following release |

## Verification
The bench targets three cases. The first is a low pulse one tick short of the limit, where a design with an off-by-one would cut off a legal frame. The second is a single low sample inside the release window, where a guard that does not restart its count would re-enable the driver too early. The third is a mode exit and re-entry with the transmit level low, where a guard that keeps its enable across modes would drive the bus at once. It also checks that the flag survives a trip out of normal mode, and that cycles without a tick advance neither timer, which a design counting clocks instead of ticks would get wrong.

// File: rtl/tdg_pkg.sv
package tdg_pkg;

    // Control state of the guard: driver enable and timeout status
    typedef struct packed {
        logic armed;
        logic flag;
    } tdg_ctl_t;

endpackage

// File: rtl/tdg_tick_cnt.sv
module tdg_tick_cnt #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic tick_i,
    output logic hit_o
);
    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign hit_o = run_i && tick_i && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!run_i || hit_o) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LAST); // R2
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (st_q.cnt == '0)); // R4

endmodule

// File: rtl/tdg_ctrl.sv
module tdg_ctrl
    import tdg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic norm_i,
    input  logic txd_i,
    input  logic tmo_hit_i,
    input  logic rel_hit_i,
    output logic low_run_o,
    output logic high_run_o,
    output logic armed_o,
    output logic flag_o
);
    tdg_ctl_t st_d, st_q;

    // Timeout counts only while enabled and low; release only while disabled and high
    assign low_run_o  = norm_i &&  st_q.armed && !txd_i;
    assign high_run_o = norm_i && !st_q.armed &&  txd_i;
    assign armed_o    = st_q.armed;
    assign flag_o     = st_q.flag;

    always_comb begin
        st_d = st_q;
        if (!norm_i) begin
            st_d.armed = 1'b0;
        end else if (tmo_hit_i) begin
            st_d.armed = 1'b0;
            st_d.flag  = 1'b1;
        end else if (rel_hit_i) begin
            st_d.armed = 1'b1;
            st_d.flag  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TMO_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_hit_i |=> (!st_q.armed && st_q.flag)); // R2
    AST_ARM_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.armed) |-> ($past(txd_i) && $past(norm_i))); // R3
    AST_OFF_OUT_OF_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !norm_i |=> !st_q.armed); // R6
    AST_FLAG_EXCLUDES_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.flag |-> !st_q.armed); // R8
    AST_RUNS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(low_run_o && high_run_o)); // R5

endmodule

// File: rtl/tdg_guard.sv
module tdg_guard #(
    parameter int unsigned TMO_TICKS = 55000,
    parameter int unsigned REL_TICKS = 11
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic txd_i,
    input  logic norm_i,
    input  logic tick_i,
    output logic drv_dom_o,
    output logic tmo_flag_o
);
    logic low_run, high_run, tmo_hit, rel_hit, armed;

    tdg_tick_cnt #(.LIMIT(TMO_TICKS)) i_tmo_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (low_run),
        .tick_i (tick_i),
        .hit_o  (tmo_hit)
    );

    tdg_tick_cnt #(.LIMIT(REL_TICKS)) i_rel_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (high_run),
        .tick_i (tick_i),
        .hit_o  (rel_hit)
    );

    tdg_ctrl i_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .norm_i     (norm_i),
        .txd_i      (txd_i),
        .tmo_hit_i  (tmo_hit),
        .rel_hit_i  (rel_hit),
        .low_run_o  (low_run),
        .high_run_o (high_run),
        .armed_o    (armed),
        .flag_o     (tmo_flag_o)
    );

    assign drv_dom_o = armed && norm_i && !txd_i;

    AST_NO_DOM_WHEN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txd_i |-> !drv_dom_o); // R1
    AST_FLAG_MEANS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_flag_o |-> !drv_dom_o); // R8

endmodule

// File: tb/test_tdg_guard.sv
module test_tdg_guard;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 4;
    localparam int REL = 3;
    localparam int NVEC = 31;
    localparam int WATCHDOG = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1;
    logic norm = 1'b0;
    logic tick = 1'b0;
    logic drv_dom, tmo_flag;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdg_guard #(.TMO_TICKS(TMO), .REL_TICKS(REL)) i_tdg_guard (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .txd_i      (txd),
        .norm_i     (norm),
        .tick_i     (tick),
        .drv_dom_o  (drv_dom),
        .tmo_flag_o (tmo_flag)
    );

    // {req[3:0], norm, txd, tick, exp_drv, exp_flag}; expectations hold before the edge
    localparam logic [8:0] VEC [NVEC] = '{
        {4'd7, 5'b10100},  // v0  R7 low txd after reset: not enabled
        {4'd3, 5'b11100},  // v1  R3 release count 1
        {4'd3, 5'b11100},  // v2  R3 count 2
        {4'd4, 5'b10100},  // v3  R4 low sample restarts release
        {4'd4, 5'b11100},  // v4  R4 count 1
        {4'd3, 5'b11000},  // v5  R3 no tick: no count
        {4'd3, 5'b11100},  // v6  R3 count 2
        {4'd3, 5'b11100},  // v7  R3 count 3: enables
        {4'd1, 5'b11100},  // v8  R1 high txd: recessive
        {4'd1, 5'b10110},  // v9  R1 low txd: dominant, tmo 1
        {4'd1, 5'b10110},  // v10 R1 tmo 2
        {4'd5, 5'b11100},  // v11 R5 high sample restarts timeout
        {4'd5, 5'b10110},  // v12 R5 tmo 1
        {4'd2, 5'b10110},  // v13 R2 tmo 2
        {4'd2, 5'b10010},  // v14 R2 no tick
        {4'd2, 5'b10110},  // v15 R2 tmo 3
        {4'd2, 5'b10110},  // v16 R2 tmo 4: expires
        {4'd2, 5'b10101},  // v17 R2 forced off, flag set
        {4'd8, 5'b11101},  // v18 R8 release 1
        {4'd8, 5'b11101},  // v19 R8 release 2
        {4'd8, 5'b01101},  // v20 R8 mode exit keeps flag
        {4'd6, 5'b11101},  // v21 R6 release restarts 1
        {4'd6, 5'b11101},  // v22 R6 release 2
        {4'd8, 5'b11101},  // v23 R8 release 3: enable, flag clears
        {4'd8, 5'b10110},  // v24 R8 flag clear, dominant
        {4'd6, 5'b00100},  // v25 R6 out of normal: off
        {4'd6, 5'b10100},  // v26 R6 re-entry with low txd: off
        {4'd6, 5'b11100},  // v27 R6 release 1
        {4'd6, 5'b11100},  // v28 R6 release 2
        {4'd6, 5'b11100},  // v29 R6 release 3
        {4'd1, 5'b10110}   // v30 R1 enabled again
    };

    task automatic check(input string req, input logic act_d, input logic exp_d,
                         input logic act_f, input logic exp_f);
        checks++;
        if (act_d !== exp_d || act_f !== exp_f) begin
            fails++;
            $display("FAIL %s: drv_dom=%b flag=%b expected drv_dom=%b flag=%b",
                     req, act_d, act_f, exp_d, exp_f);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        // R7 reset state, driven low txd in normal mode
        norm = 1'b1;
        txd  = 1'b0;
        repeat (3) @(negedge clk);
        #1 check("R7", drv_dom, 1'b0, tmo_flag, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            norm = VEC[i][4];
            txd  = VEC[i][3];
            tick = VEC[i][2];
            #1 check($sformatf("R%0d v%0d", VEC[i][8:5], i), drv_dom, VEC[i][1], tmo_flag, VEC[i][0]);
        end

        // R2 exactly one tick short of the limit does not expire
        @(negedge clk); txd = 1'b1; tick = 1'b1;
        for (int k = 0; k < TMO - 1; k++) begin
            @(negedge clk); txd = 1'b0;
        end
        @(negedge clk); txd = 1'b1;
        #1 check("R2 short pulse", drv_dom, 1'b0, tmo_flag, 1'b0);
        @(negedge clk); txd = 1'b0;
        #1 check("R2 still enabled", drv_dom, 1'b1, tmo_flag, 1'b0);

        // R7 reset during an active timeout clears flag and enable
        for (int k = 0; k < TMO + 1; k++) @(negedge clk);
        #1 check("R2 expiry", drv_dom, 1'b0, tmo_flag, 1'b1);
        rst_n = 1'b0;
        #1 check("R7 in reset", drv_dom, 1'b0, tmo_flag, 1'b0);
        @(negedge clk); rst_n = 1'b1; txd = 1'b0;
        @(negedge clk);
        #1 check("R7 after reset needs release", drv_dom, 1'b0, tmo_flag, 1'b0);

        // R3 release with sparse ticks: two idle cycles between ticks
        txd = 1'b1;
        for (int k = 0; k < REL; k++) begin
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); txd = 1'b0; tick = 1'b0;
        #1 check("R3 sparse release", drv_dom, 1'b1, tmo_flag, 1'b0);

        @(negedge clk);
        finish_run();
    end
endmodule